// File: doc/BRIEF.md
# Configurable Pixel Colour Component Extractor

This block sits between a display controller's pixel fetch path and its video output. It takes one raw pixel word per clock, 1 to 4 bytes wide, and turns it into three 8-bit colour components: red, green and blue. Software chooses where each component sits inside the pixel and how wide it is. Software also sets how many bytes of the fetched word are real pixel data. Each component carries its own 8-bit fallback value. The fallback replaces the extracted field in three cases: the field is programmed with zero width, the beam is outside the visible area, or the pixel supply has run dry. Giving red a fallback of 0xFF therefore makes supply underruns show up as red on screen.

The outputs are registered. Horizontal sync, vertical sync and the visible-area flag go through the same one-cycle delay, so the colour and timing signals stay aligned.

Top module: `pix_comp_extract`

## Requirements
- R1: While rst_ni is low, red_o, grn_o, blu_o, hsync_o, vsync_o and de_o are all zero.
- R2: Component outputs, hsync_o, vsync_o and de_o change only on the clock edge that samples the matching inputs. They reflect those inputs one cycle later, and de_o is the delayed active_i.
- R3: Each select word (sel_r_i, sel_g_i, sel_b_i) uses these fields: bits [4:0] give the index of the lowest pixel bit of the field, bits [11:8] give the field width in bits (0 to 15), and bits [23:16] give the fallback value.
- R4: Bits [4:3] of fmt_i hold bytes-per-pixel minus one, so 0 means one byte. Pixel bits at or above 8 × bytes-per-pixel read as zero.
- R5: A field narrower than 8 bits is placed at the top of the 8-bit output, and its bits are repeated from its own top bit downward to fill the remaining low bits.
- R6: A field wider than 8 bits outputs its 8 most significant bits.
- R7: A component whose width field is zero outputs its fallback value.
- R8: When active_i is low, all three components output their fallback values.
- R9: An underrun makes all three components output their fallback values. An underrun is underrun_i high, or active_i high while pix_vld_i is low.
- R10: Field bits that fall above bit 31 of the pixel word read as zero.
- R11: Each component is extracted only from its own select word, so the three components can use different offsets, widths and fallbacks at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 8 | Pixel format word; bits [4:3] = bytes per pixel minus one |
| sel_r_i | input | 24 | Red select: offset, width, fallback |
| sel_g_i | input | 24 | Green select: offset, width, fallback |
| sel_b_i | input | 24 | Blue select: offset, width, fallback |
| pix_i | input | 32 | Raw pixel word, little-endian byte order |
| pix_vld_i | input | 1 | Pixel word is valid |
| underrun_i | input | 1 | Pixel supply has underrun |
| active_i | input | 1 | Pixel lies in the visible area |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| red_o | output | 8 | Red component |
| grn_o | output | 8 | Green component |
| blu_o | output | 8 | Blue component |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed visible-area flag |

## Verification
The hardest situations to reach are fields that cross a boundary: a field that runs past the last valid byte of a narrow pixel, and a field that runs off the top of the 32-bit word. In both cases the stimulus places all-ones bit patterns above the boundary, so any bit that leaks through changes the output. The bench pairs a high offset with a wide field, and a one-byte format with a field straddling bit 8.

Replication is tested with widths of 1, 3, 5 and 6 bits. Each width gives a different repeat pattern that a plain left shift would not produce.

The underrun path is driven two ways: through the underrun flag, and through a missing valid flag inside the visible area. Both are driven with nonzero pixel data, so the fallback value has to win over a real extraction.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int COMP_W      = 8;
  localparam int SEL_OFF_LSB = 0;
  localparam int SEL_OFF_W   = 5;
  localparam int SEL_LEN_LSB = 8;
  localparam int SEL_LEN_W   = 4;
  localparam int SEL_DEF_LSB = 16;
  localparam int SEL_W       = SEL_DEF_LSB + COMP_W;
  localparam int FMT_BPP_LSB = 3;
  localparam int FMT_BPP_W   = 2;
  localparam int FMT_W       = 8;
  localparam int MAX_LEN     = 1 << SEL_LEN_W;

  typedef struct packed {
    logic [COMP_W-1:0]    dflt;
    logic [SEL_LEN_W-1:0] len;
    logic [SEL_OFF_W-1:0] off;
  } sel_t;

  function automatic sel_t unpack_sel(input logic [SEL_W-1:0] raw);
    sel_t s;
    s.off  = raw[SEL_OFF_LSB +: SEL_OFF_W];
    s.len  = raw[SEL_LEN_LSB +: SEL_LEN_W];
    s.dflt = raw[SEL_DEF_LSB +: COMP_W];
    return s;
  endfunction
endpackage

// File: rtl/pce_byte_mask.sv
module pce_byte_mask
  import pce_pkg::*;
#(
  parameter int PIX_BYTES = 4
) (
  input  logic [FMT_BPP_W-1:0]   bpp_m1_i,
  input  logic [PIX_BYTES*8-1:0] pix_i,
  output logic [PIX_BYTES*8-1:0] pix_o
);
  for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
    localparam logic [FMT_BPP_W:0] BIDX = (FMT_BPP_W+1)'(b);
    logic keep;
    assign keep = BIDX <= {1'b0, bpp_m1_i};
    assign pix_o[b*8 +: 8] = keep ? pix_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pce_comp_unit.sv
module pce_comp_unit
  import pce_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic [PIX_W-1:0]  pix_i,
  input  sel_t              sel_i,
  input  logic              force_dflt_i,
  output logic [COMP_W-1:0] val_o
);
  localparam int WIDE_W = 2 * PIX_W;

  logic [WIDE_W-1:0]    wide;
  logic [MAX_LEN-1:0]   field;
  logic [COMP_W-1:0]    packed_val;
  logic [SEL_LEN_W-1:0] idx;
  logic                 unused_wide;

  // zero extension makes bits above the word read as zero
  assign wide        = {{PIX_W{1'b0}}, pix_i} >> sel_i.off;
  assign field       = wide[MAX_LEN-1:0];
  assign unused_wide = ^wide[WIDE_W-1:MAX_LEN];

  // walk the field from its msb down, wrapping for short fields
  always_comb begin
    packed_val = '0;
    idx        = sel_i.len - 1'b1;
    for (int k = 0; k < COMP_W; k++) begin
      packed_val[COMP_W-1-k] = field[idx];
      if (idx == '0) idx = sel_i.len - 1'b1;
      else           idx = idx - 1'b1;
    end
  end

  assign val_o = (force_dflt_i || sel_i.len == '0) ? sel_i.dflt : packed_val;
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
  import pce_pkg::*;
#(
  parameter int PIX_BYTES = 4,
  parameter int NCOMP     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FMT_W-1:0]    fmt_i,
  input  logic [SEL_W-1:0]    sel_r_i,
  input  logic [SEL_W-1:0]    sel_g_i,
  input  logic [SEL_W-1:0]    sel_b_i,
  input  logic [PIX_BYTES*8-1:0] pix_i,
  input  logic                pix_vld_i,
  input  logic                underrun_i,
  input  logic                active_i,
  input  logic                hsync_i,
  input  logic                vsync_i,
  output logic [COMP_W-1:0]   red_o,
  output logic [COMP_W-1:0]   grn_o,
  output logic [COMP_W-1:0]   blu_o,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o
);
  localparam int PIX_W = PIX_BYTES * 8;

  logic [PIX_W-1:0]  pix_m;
  logic              starve;
  logic              force_dflt;
  logic [SEL_W-1:0]  sel_raw [NCOMP];
  logic [COMP_W-1:0] comb_val [NCOMP];
  logic [COMP_W-1:0] out_q [NCOMP];
  logic              unused_fmt;

  assign unused_fmt = ^{fmt_i[FMT_W-1:FMT_BPP_LSB+FMT_BPP_W], fmt_i[FMT_BPP_LSB-1:0],
                        sel_r_i[15:12], sel_r_i[7:5], sel_g_i[15:12], sel_g_i[7:5],
                        sel_b_i[15:12], sel_b_i[7:5]};

  assign sel_raw[0] = sel_r_i;
  assign sel_raw[1] = sel_g_i;
  assign sel_raw[2] = sel_b_i;

  assign starve     = underrun_i | (active_i & ~pix_vld_i);
  assign force_dflt = ~active_i | starve;

  pce_byte_mask #(.PIX_BYTES(PIX_BYTES)) u_mask (
    .bpp_m1_i (fmt_i[FMT_BPP_LSB +: FMT_BPP_W]),
    .pix_i    (pix_i),
    .pix_o    (pix_m)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    pce_comp_unit #(.PIX_W(PIX_W)) u_unit (
      .pix_i        (pix_m),
      .sel_i        (unpack_sel(sel_raw[c])),
      .force_dflt_i (force_dflt),
      .val_o        (comb_val[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q[c] <= '0;
      else         out_q[c] <= comb_val[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
    end else begin
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
      de_o    <= active_i;
    end
  end

  assign red_o = out_q[0];
  assign grn_o = out_q[1];
  assign blu_o = out_q[2];
endmodule

// File: rtl/pce_checker.sv
module pce_checker
  import pce_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  sel_r_i,
  input logic [SEL_W-1:0]  sel_g_i,
  input logic [SEL_W-1:0]  sel_b_i,
  input logic              pix_vld_i,
  input logic              underrun_i,
  input logic              active_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic [COMP_W-1:0] red_o,
  input logic [COMP_W-1:0] grn_o,
  input logic [COMP_W-1:0] blu_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              de_o
);
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (red_o == 8'h0 && grn_o == 8'h0 && blu_o == 8'h0 && !de_o)); // R1

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hsync_o == $past(hsync_i) && vsync_o == $past(vsync_i) && de_o == $past(active_i))); // R2

  AST_BLANK_DFLT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (red_o == $past(sel_r_i[23:16]) && grn_o == $past(sel_g_i[23:16])
                   && blu_o == $past(sel_b_i[23:16]))); // R8

  AST_UNDERRUN_DFLT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_i || (active_i && !pix_vld_i)) |=> (red_o == $past(sel_r_i[23:16])
      && grn_o == $past(sel_g_i[23:16]) && blu_o == $past(sel_b_i[23:16]))); // R9

  AST_ZERO_LEN_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_r_i[11:8] == 4'h0) |=> red_o == $past(sel_r_i[23:16])); // R7

  AST_ZERO_LEN_GRN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_g_i[11:8] == 4'h0) |=> grn_o == $past(sel_g_i[23:16])); // R7
endmodule

bind pix_comp_extract pce_checker u_chk (.*);

// File: tb/pix_comp_extract_tb.sv
`timescale 1ns/1ps
module pix_comp_extract_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  fmt_i = '0;
  logic [23:0] sel_r_i = '0, sel_g_i = '0, sel_b_i = '0;
  logic [31:0] pix_i = '0;
  logic        pix_vld_i = 1'b0, underrun_i = 1'b0, active_i = 1'b0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0;
  logic [7:0]  red_o, grn_o, blu_o;
  logic        hsync_o, vsync_o, de_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  pix_comp_extract u_dut (.*);

  function automatic logic [23:0] mk_sel(int off, int len, logic [7:0] d);
    return {d, 4'h0, 4'(len), 3'h0, 5'(off)};
  endfunction

  function automatic logic [7:0] mk_fmt(int bpp);
    return 8'((bpp - 1) << 3);
  endfunction

  // independent model: mask, shift, then build by repeated concatenation
  function automatic logic [7:0] model(logic [31:0] pix, logic [7:0] fmt, logic [23:0] sel,
                                       logic act, logic vld, logic und);
    longint unsigned p, f, r;
    int bpp, off, len, bits;
    bpp = int'(fmt[4:3]) + 1;
    off = int'(sel[4:0]);
    len = int'(sel[11:8]);
    if (!act || und || !vld || len == 0) return sel[23:16];
    p = longint'(pix) & ((64'd1 << (8 * bpp)) - 1);
    f = (p >> off) & ((64'd1 << len) - 1);
    if (len >= 8) return 8'(f >> (len - 8));
    r = 0; bits = 0;
    while (bits < 8) begin r = (r << len) | f; bits += len; end
    return 8'(r >> (bits - 8));
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_pix(string req, logic [31:0] pix, logic [7:0] fmt,
                         logic [23:0] sr, logic [23:0] sg, logic [23:0] sb,
                         logic act, logic vld, logic und);
    @(negedge clk_i);
    pix_i = pix; fmt_i = fmt; sel_r_i = sr; sel_g_i = sg; sel_b_i = sb;
    active_i = act; pix_vld_i = vld; underrun_i = und;
    @(negedge clk_i);
    chk(req, "red", red_o, model(pix, fmt, sr, act, vld, und));
    chk(req, "grn", grn_o, model(pix, fmt, sg, act, vld, und));
    chk(req, "blu", blu_o, model(pix, fmt, sb, act, vld, und));
  endtask

  task automatic t_reset();
    chk("R1", "red", red_o, 8'h00);
    chk("R1", "grn", grn_o, 8'h00);
    chk("R1", "blu", blu_o, 8'h00);
    chk("R1", "sync", {5'b0, hsync_o, vsync_o, de_o}, 8'h00);
  endtask

  task automatic t_rgb888();
    run_pix("R3", 32'h00_a1_b2_c3, mk_fmt(3), mk_sel(16, 8, 8'h11), mk_sel(8, 8, 8'h22),
            mk_sel(0, 8, 8'h33), 1, 1, 0);
    run_pix("R11", 32'h12_34_56_78, mk_fmt(4), mk_sel(0, 8, 8'h01), mk_sel(24, 8, 8'h02),
            mk_sel(12, 8, 8'h03), 1, 1, 0);
  endtask

  task automatic t_short();
    run_pix("R5", 32'h0000_f81f, mk_fmt(2), mk_sel(11, 5, 8'h00), mk_sel(5, 6, 8'h00),
            mk_sel(0, 5, 8'h00), 1, 1, 0);
    run_pix("R5", 32'h0000_a5b6, mk_fmt(2), mk_sel(11, 5, 8'h00), mk_sel(0, 3, 8'h00),
            mk_sel(7, 1, 8'h00), 1, 1, 0);
    chk("R5", "grn 3b 110", grn_o, 8'hdb);
  endtask

  task automatic t_long();
    run_pix("R6", 32'h0003_c5a0, mk_fmt(4), mk_sel(4, 12, 8'h00), mk_sel(2, 15, 8'h00),
            mk_sel(8, 9, 8'h00), 1, 1, 0);
  endtask

  task automatic t_bounds();
    run_pix("R4", 32'hffff_ff3c, mk_fmt(1), mk_sel(4, 8, 8'h00), mk_sel(0, 12, 8'h00),
            mk_sel(8, 4, 8'h77), 1, 1, 0);
    chk("R4", "red upper nibble zero", red_o, 8'h03);
    run_pix("R10", 32'hf000_0000, mk_fmt(4), mk_sel(28, 8, 8'h00), mk_sel(30, 15, 8'h00),
            mk_sel(31, 1, 8'h00), 1, 1, 0);
    chk("R10", "red top bits only", red_o, 8'h0f);
  endtask

  task automatic t_zero_len();
    run_pix("R7", 32'hffff_ffff, mk_fmt(4), mk_sel(0, 8, 8'h5a), mk_sel(3, 0, 8'h6b),
            mk_sel(9, 0, 8'h7c), 1, 1, 0);
    chk("R7", "grn dflt", grn_o, 8'h6b);
  endtask

  task automatic t_blank_underrun();
    run_pix("R8", 32'h00ff_ffff, mk_fmt(3), mk_sel(16, 8, 8'h10), mk_sel(8, 8, 8'h20),
            mk_sel(0, 8, 8'h30), 0, 1, 0);
    run_pix("R9", 32'h00ff_ffff, mk_fmt(3), mk_sel(16, 8, 8'hff), mk_sel(8, 8, 8'h00),
            mk_sel(0, 8, 8'h00), 1, 1, 1);
    chk("R9", "red underrun", red_o, 8'hff);
    run_pix("R9", 32'h00ff_ffff, mk_fmt(3), mk_sel(16, 8, 8'h44), mk_sel(8, 8, 8'h55),
            mk_sel(0, 8, 8'h66), 1, 0, 0);
  endtask

  task automatic t_latency();
    run_pix("R2", 32'h0000_00aa, mk_fmt(1), mk_sel(0, 8, 8'h00), mk_sel(0, 8, 8'h00),
            mk_sel(0, 8, 8'h00), 1, 1, 0);
    @(negedge clk_i);
    pix_i = 32'h0000_0055; hsync_i = 1'b1; vsync_i = 1'b0; active_i = 1'b0;
    #1;
    chk("R2", "red held before edge", red_o, 8'haa);
    chk("R2", "de held before edge", {7'b0, de_o}, 8'h01);
    @(negedge clk_i);
    chk("R2", "hsync delayed", {7'b0, hsync_o}, 8'h01);
    chk("R2", "de delayed", {7'b0, de_o}, 8'h00);
    vsync_i = 1'b1; hsync_i = 1'b0; active_i = 1'b1;
    @(negedge clk_i);
    chk("R2", "vsync delayed", {6'b0, hsync_o, vsync_o}, 8'h01);
    chk("R2", "red after edge", red_o, 8'h55);
  endtask

  initial begin
    fork
      begin
        #10;
        t_reset();
        @(negedge clk_i);
        rst_ni = 1'b1;
        t_rgb888();
        t_short();
        t_long();
        t_bounds();
        t_zero_len();
        t_blank_underrun();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule